// File: doc/BRIEF.md
# Capture-to-Playback Loopback and Side-Tone Mixer

This block sits in the digital datapath of a voice codec. The capture filter delivers 16-bit samples with a valid strobe. The host supplies playback samples, and the DAC interpolator asks for one sample per strobe. On each strobe the block chooses what the DAC receives. In normal operation that is the playback sample with an attenuated copy of the latest capture sample added on top (side-tone), saturated to the sample width. Digital loopback replaces the playback stream with the captured signal. A request for analog loopback wins over everything else: the digital path then passes playback data untouched, and a flag tells the analog section to close its own loop.

Side-tone level comes from a 3-bit code. The code gives attenuation in 3 dB steps, and its top value switches side-tone off. The output is registered and has one cycle of latency from the DAC strobe.

Top module: `lb_sidetone_mixer`

## Requirements
- R1: During and right after reset, dac_sample is 0, dac_valid is 0 and ana_loop_req is 0.
- R2: dac_valid is high in exactly the cycles that follow a cycle with dac_strobe high, and dac_sample takes its new value in those cycles. In any other cycle dac_sample holds its previous value.
- R3: The capture value used on a strobe is adc_sample if adc_valid is high in that same cycle. Otherwise it is the last adc_sample accepted with adc_valid, or 0 if none has been accepted since reset. A capture with no strobe does not change dac_sample.
- R4: With dig_loop_en=1 and ana_loop_en=0, a strobe loads the capture value into dac_sample unchanged. Neither playback data nor side-tone is added.
- R5: With ana_loop_en=1, a strobe loads play_sample into dac_sample unchanged, whatever the values of dig_loop_en and st_gain.
- R6: ana_loop_req equals the value ana_loop_en had one cycle earlier.
- R7: With both loopbacks off and st_gain=k in 0..6, a strobe loads sat(play + floor(cap*C_k/16384)). Here C_k = round(16384*10^(-3k/20)), which gives 16384, 11599, 8211, 5813, 4115, 2914 and 2063 for k=0 to 6.
- R8: With both loopbacks off and st_gain=7, side-tone is off and a strobe loads play_sample unchanged.
- R9: sat() clamps the sum to the signed 16-bit range: any result above 32767 gives 32767, and any result below -32768 gives -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_sample | input | 16 | Signed capture sample from the decimator |
| adc_valid | input | 1 | adc_sample is valid this cycle |
| play_sample | input | 16 | Signed playback sample from the host side |
| dac_strobe | input | 1 | DAC requests a sample this cycle |
| dig_loop_en | input | 1 | Route the capture signal to the DAC |
| ana_loop_en | input | 1 | Analog loopback request; overrides the digital loopback |
| st_gain | input | 3 | Side-tone attenuation code, 3 dB per step; 7 = off |
| dac_sample | output | 16 | Signed sample for the interpolator |
| dac_valid | output | 1 | dac_sample was updated this cycle |
| ana_loop_req | output | 1 | Registered analog-loopback flag to the analog section |

## Verification
The bench builds the block with its default 16-bit sample width. At that width, every side-tone code can be swept against a fixed set of capture and playback values. The set includes both extremes of the signed range, plus and minus one, and zero, so it reaches both saturation rails and the floor rounding of negative products. The bench computes each attenuation coefficient from the dB formula with real arithmetic. It also steps through every combination of the two loopback bits and checks that captures and non-strobe cycles leave the output unchanged.

// File: rtl/lb_sidetone_mixer.sv
module lb_sidetone_mixer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] adc_sample,
  input  logic         adc_valid,
  input  logic [W-1:0] play_sample,
  input  logic         dac_strobe,
  input  logic         dig_loop_en,
  input  logic         ana_loop_en,
  input  logic [2:0]   st_gain,
  output logic [W-1:0] dac_sample,
  output logic         dac_valid,
  output logic         ana_loop_req
);
  localparam int FRAC = 14;
  localparam int CW   = FRAC + 1;
  localparam int PW   = W + CW;

  logic [W-1:0]  cap_q;
  logic [W-1:0]  cap_now;
  logic [CW-1:0] coef;
  logic [PW-1:0] prod;
  logic [W-1:0]  atten;
  logic [W:0]    sum;
  logic [W-1:0]  mixed;
  logic [W-1:0]  next_out;

  assign cap_now = adc_valid ? adc_sample : cap_q;

  always_comb begin
    case (st_gain)
      3'd0:    coef = CW'(16384);
      3'd1:    coef = CW'(11599);
      3'd2:    coef = CW'(8211);
      3'd3:    coef = CW'(5813);
      3'd4:    coef = CW'(4115);
      3'd5:    coef = CW'(2914);
      3'd6:    coef = CW'(2063);
      default: coef = '0;
    endcase
  end

  assign prod  = {{CW{cap_now[W-1]}}, cap_now} * {{W{1'b0}}, coef};
  assign atten = prod[FRAC+W-1:FRAC];
  assign sum   = {play_sample[W-1], play_sample} + {atten[W-1], atten};

  always_comb begin
    if (sum[W] != sum[W-1])
      mixed = sum[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    else
      mixed = sum[W-1:0];
  end

  always_comb begin
    if (ana_loop_en)      next_out = play_sample;
    else if (dig_loop_en) next_out = cap_now;
    else                  next_out = mixed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q        <= '0;
      dac_sample   <= '0;
      dac_valid    <= 1'b0;
      ana_loop_req <= 1'b0;
    end else begin
      if (adc_valid) cap_q <= adc_sample;
      if (dac_strobe) dac_sample <= next_out;
      dac_valid    <= dac_strobe;
      ana_loop_req <= ana_loop_en;
    end
  end
endmodule

// File: rtl/lb_sidetone_mixer_chk.sv
module lb_sidetone_mixer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] adc_sample,
  input logic         adc_valid,
  input logic [W-1:0] play_sample,
  input logic         dac_strobe,
  input logic         dig_loop_en,
  input logic         ana_loop_en,
  input logic [2:0]   st_gain,
  input logic [W-1:0] dac_sample,
  input logic         dac_valid,
  input logic         ana_loop_req
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |=> dac_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_strobe |=> (!dac_valid && $stable(dac_sample)));
  assert_analog_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && ana_loop_en) |=> dac_sample == $past(play_sample));
  assert_digital_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && adc_valid && dig_loop_en && !ana_loop_en) |=> dac_sample == $past(adc_sample));
  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ana_loop_req == $past(ana_loop_en));
  assert_sidetone_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe && !ana_loop_en && !dig_loop_en && st_gain == 3'd7) |=> dac_sample == $past(play_sample));
endmodule

bind lb_sidetone_mixer lb_sidetone_mixer_chk #(.W(W)) u_chk (.*);

// File: tb/lb_sidetone_mixer_tb.sv
module lb_sidetone_mixer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        adc_valid = 1'b0;
  logic [15:0] play_sample = '0;
  logic        dac_strobe = 1'b0;
  logic        dig_loop_en = 1'b0;
  logic        ana_loop_en = 1'b0;
  logic [2:0]  st_gain = 3'd7;
  logic [15:0] dac_sample;
  logic        dac_valid;
  logic        ana_loop_req;

  int vectors = 0;
  int errors = 0;
  int cap_m = 0;
  int out_m = 0;
  int coef_m [8];
  int pat [8] = '{0, 1, -1, 32767, -32768, 12345, -20000, 101};

  always #2.5 clk = ~clk;

  lb_sidetone_mixer u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic step(input int a, input bit av, input int p, input bit st,
                      input bit dg, input bit an, input int g, input string req);
    int cap_use;
    int expv;
    adc_sample = 16'(a); adc_valid = av; play_sample = 16'(p);
    dac_strobe = st; dig_loop_en = dg; ana_loop_en = an; st_gain = 3'(g);
    cap_use = av ? a : cap_m;
    if (an) expv = p;
    else if (dg) expv = cap_use;
    else expv = sat16(p + ((cap_use * coef_m[g]) >>> 14));
    @(posedge clk);
    if (av) cap_m = a;
    if (st) out_m = expv;
    @(negedge clk);
    check(req, int'($signed(dac_sample)), out_m);
    check({req, "/valid"}, int'(dac_valid), int'(st));
    check("R6", int'(ana_loop_req), int'(an));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) coef_m[k] = $rtoi(16384.0 * (10.0 ** (-0.15 * k)) + 0.5);
    coef_m[7] = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(dac_sample), 0);
    check("R1", int'(dac_valid), 0);
    check("R1", int'(ana_loop_req), 0);
    rst_n = 1'b1;
    // R3: no capture yet, side-tone from zero capture
    step(0, 0, 500, 1, 0, 0, 0, "R3");
    // R3: capture without strobe leaves output alone (R2 hold)
    step(9000, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 10, 1, 0, 0, 0, "R3");
    // R7, R9: sweep codes, capture values and playback values
    for (int g = 0; g < 8; g++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          step(pat[i], 1, pat[j], 1, 0, 0, g, g == 7 ? "R8" : "R7/R9");
    // held capture applied over several strobes
    step(-20000, 1, 0, 0, 0, 0, 0, "R2");
    for (int g = 0; g < 8; g++) step(0, 0, -32768, 1, 0, 0, g, "R3/R9");
    // loopback mode combinations
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 8; i++)
        for (int g = 0; g < 8; g += 3) begin
          step(pat[i], 1, pat[7 - i], 1, m[0], m[1], g, m[1] ? "R5" : (m[0] ? "R4" : "R7"));
          step(0, 0, 77, 0, m[0], m[1], g, "R2");
          step(0, 0, pat[i], 1, m[0], m[1], g, m[1] ? "R5" : (m[0] ? "R4" : "R7"));
        end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule